// File: doc/BRIEF.md
# Watchdog Timer with Partial-Clear Prescaler

This block guards a processor against runaway code. The input clock runs a 12-stage binary prescaler, whose carries drive a 6-bit timeout counter. When that counter wraps, the block drives a reset pulse of fixed length and records in a sticky flag that the watchdog was the cause. Software keeps the reset away by writing any value to the service address (all ones on the 16-bit bus) more often than the timeout.

A service write clears the timeout counter and the upper eight prescaler stages only. The lowest four stages keep counting, so the time left after a service depends on their phase. With the long rate the counter advances on each carry out of the top prescaler stage, which gives 2^18 clocks from a full clear. With the short rate it advances on each carry out of stage 7, which gives 2^13 clocks. At an 88 kHz clock the short rate lasts roughly 93 ms.

The following hold the whole chain at zero: a power-on or system reset, stop mode, a reset-vector fetch, the disable input, and the block's own reset pulse. There is no data stream, so nothing here uses valid/ready. The service write is a plain strobe with an address. It is taken in any cycle and never stalls, so there is no back-pressure.

Top module: `watchdog_timer`

## Requirements
- R1: After power-on reset, `wd_rst` and `wd_flag` are both 0.
- R2: With `rate_short` = 0, `wd_rst` rises exactly T_L = 2^(PRE_W+CNT_W) rising edges (2^18 at defaults) after the last edge at which the chain was fully cleared, if nothing clears it in between.
- R3: With `rate_short` = 1, the counter steps on carries out of stage SHORT_TAP (stage 7), and `wd_rst` rises exactly T_S = 2^(SHORT_TAP+CNT_W) edges (2^13 at defaults) after a full clear.
- R4: A write strobe with `bus_addr` equal to all ones clears the counter and the prescaler stages above the lowest KEEP_LOW = 4. The low stages keep counting. If L is the value of the four low stages just after the service edge, `wd_rst` rises T − L edges after that edge.
- R5: An address of all ones without the strobe, or the strobe with any other address, has no effect on the timing.
- R6: A service write sampled at the same edge as a counter wrap wins: no reset is produced at that edge.
- R7: While `wd_dis` is 1 the chain is held at zero and `wd_rst` never rises. When `wd_dis` drops, a full timeout T starts.
- R8: While `stop_mode` is 1 the chain is held at zero and does not count. A full timeout starts when it drops.
- R9: `sys_rst` and `vec_fetch` clear every stage, including the four low stages.
- R10: `wd_rst` stays high for exactly 32 clocks. The chain is held at zero during the pulse, so the next timeout is a full T after the pulse ends.
- R11: `wd_flag` is set with the pulse. It survives `sys_rst` and is cleared only by `por`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| por | input | 1 | Power-on reset, active high, synchronous; clears everything including the flag |
| sys_rst | input | 1 | System reset, active high; clears the timeout chain |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 16 | Bus address; all ones is the service address |
| rate_short | input | 1 | Static rate select: 0 long timeout, 1 short timeout |
| wd_dis | input | 1 | Disable: holds the chain clear and blocks any reset |
| stop_mode | input | 1 | Stop mode indication; holds the chain clear |
| vec_fetch | input | 1 | Reset-vector fetch indication; clears the chain |
| wd_rst | output | 1 | Watchdog reset pulse, 32 clocks long |
| wd_flag | output | 1 | Sticky: the watchdog caused a reset |

## Verification
A service write and a counter wrap can fall in the same cycle. The bench provokes this by placing the write strobe exactly on the edge where the wrap would occur. It also places a write one edge before that edge. The collision is judged by the absence of a pulse and by the exact length of the following timeout, which must equal T minus the low-stage phase. A design in which the wrap won would pulse one cycle after the write.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  // Clear requests applied to the timeout chain at the next edge.
  typedef struct packed {
    logic full;   // every prescaler stage and the counter
    logic upper;  // counter and prescaler stages above the kept low ones
  } wdt_clr_t;

  typedef enum logic {
    RATE_LONG  = 1'b0,
    RATE_SHORT = 1'b1
  } wdt_rate_e;
endpackage

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int PRE_W     = 12,
  parameter int KEEP_LOW  = 4,
  parameter int SHORT_TAP = 7
) (
  input  logic     clk,
  input  wdt_clr_t clr,
  output logic     carry_long,
  output logic     carry_short
);
  localparam logic [PRE_W-1:0] PS_ONE = PRE_W'(1);

  logic [PRE_W-1:0] ps;
  logic [PRE_W-1:0] ps_nxt;
  logic [PRE_W-1:0] chain;

  // Ripple carry: chain[i] means stages 0..i are all ones.
  assign chain[0] = ps[0];
  for (genvar i = 1; i < PRE_W; i++) begin : g_carry
    assign chain[i] = chain[i-1] & ps[i];
  end

  assign carry_long  = chain[PRE_W-1];
  assign carry_short = chain[SHORT_TAP-1];

  always_comb begin
    ps_nxt = ps + PS_ONE;
    if (clr.upper) ps_nxt[PRE_W-1:KEEP_LOW] = '0;
  end

  always_ff @(posedge clk) begin
    if (clr.full) ps <= '0;
    else          ps <= ps_nxt;
  end
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic     clk,
  input  wdt_clr_t clr,
  input  logic     tick,
  output logic     overflow
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             any_clr;

  assign any_clr  = clr.full | clr.upper;
  assign overflow = tick & (&cnt) & ~any_clr;

  always_ff @(posedge clk) begin
    if (any_clr)   cnt <= '0;
    else if (tick) cnt <= cnt + CNT_ONE;
  end
endmodule

// File: rtl/wdt_pulse.sv
`timescale 1ns/1ps
module wdt_pulse #(
  parameter int PULSE_LEN = 32
) (
  input  logic clk,
  input  logic por,
  input  logic fire,
  output logic active,
  output logic flag
);
  localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN - 1);
  localparam logic [PW-1:0] P_ONE = PW'(1);

  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (por) begin
      active <= 1'b0;
      left   <= '0;
      flag   <= 1'b0;
    end else if (fire) begin
      active <= 1'b1;
      left   <= LOAD;
      flag   <= 1'b1;
    end else if (active) begin
      if (left == '0) active <= 1'b0;
      else            left   <= left - P_ONE;
    end
  end
endmodule

// File: rtl/watchdog_timer.sv
`timescale 1ns/1ps
module watchdog_timer
  import wdt_pkg::*;
#(
  parameter int              PRE_W     = 12,
  parameter int              CNT_W     = 6,
  parameter int              SHORT_TAP = 7,
  parameter int              KEEP_LOW  = 4,
  parameter int              PULSE_LEN = 32,
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input  logic              clk,
  input  logic              por,
  input  logic              sys_rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              rate_short,
  input  logic              wd_dis,
  input  logic              stop_mode,
  input  logic              vec_fetch,
  output logic              wd_rst,
  output logic              wd_flag
);
  wdt_clr_t  clr;
  wdt_rate_e rate;
  logic      carry_long;
  logic      carry_short;
  logic      tick;
  logic      overflow;

  assign rate      = wdt_rate_e'(rate_short);
  assign clr.full  = por | sys_rst | stop_mode | vec_fetch | wd_dis | wd_rst;
  assign clr.upper = bus_wr & (bus_addr == SVC_ADDR);
  assign tick      = (rate == RATE_SHORT) ? carry_short : carry_long;

  wdt_prescaler #(
    .PRE_W(PRE_W), .KEEP_LOW(KEEP_LOW), .SHORT_TAP(SHORT_TAP)
  ) u_pre (
    .clk(clk), .clr(clr), .carry_long(carry_long), .carry_short(carry_short)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .clr(clr), .tick(tick), .overflow(overflow)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .por(por), .fire(overflow), .active(wd_rst), .flag(wd_flag)
  );
endmodule

// File: rtl/watchdog_timer_chk.sv
`timescale 1ns/1ps
module watchdog_timer_chk #(
  parameter int                PULSE_LEN = 32,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = '1
) (
  input logic              clk,
  input logic              por,
  input logic              sys_rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd_dis,
  input logic              stop_mode,
  input logic              wd_rst,
  input logic              wd_flag
);
  logic [7:0] hi_run;

  always_ff @(posedge clk) begin
    if (por)         hi_run <= '0;
    else if (wd_rst) hi_run <= (hi_run == 8'hFF) ? hi_run : hi_run + 8'd1;
    else             hi_run <= '0;
  end

  // R7
  dis_blocks_rst_chk: assert property (@(posedge clk) disable iff (por)
    wd_dis |=> !$rose(wd_rst));

  // R8
  stop_blocks_rst_chk: assert property (@(posedge clk) disable iff (por)
    stop_mode |=> !$rose(wd_rst));

  // R6
  svc_blocks_rst_chk: assert property (@(posedge clk) disable iff (por)
    (bus_wr && bus_addr == SVC_ADDR) |=> !$rose(wd_rst));

  // R9
  sysrst_blocks_rst_chk: assert property (@(posedge clk) disable iff (por)
    sys_rst |=> !$rose(wd_rst));

  // R10
  pulse_len_max_chk: assert property (@(posedge clk) disable iff (por)
    wd_rst |-> (32'(hi_run) < PULSE_LEN));

  // R10
  pulse_len_exact_chk: assert property (@(posedge clk) disable iff (por)
    $fell(wd_rst) |-> (32'(hi_run) == PULSE_LEN));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (por)
    wd_flag |=> wd_flag);

  // R11
  rise_sets_flag_chk: assert property (@(posedge clk) disable iff (por)
    $rose(wd_rst) |-> wd_flag);
endmodule

bind watchdog_timer watchdog_timer_chk #(
  .PULSE_LEN(PULSE_LEN), .ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)
) u_chk (
  .clk(clk), .por(por), .sys_rst(sys_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd_dis(wd_dis), .stop_mode(stop_mode), .wd_rst(wd_rst), .wd_flag(wd_flag)
);

// File: tb/sim_watchdog_timer.sv
`timescale 1ns/1ps
module sim_watchdog_timer;
  localparam int PRE_W     = 9;
  localparam int CNT_W     = 6;
  localparam int SHORT_TAP = 5;
  localparam int KEEP_LOW  = 4;
  localparam int PULSE_LEN = 32;
  localparam int T_L       = 1 << (PRE_W + CNT_W);
  localparam int T_S       = 1 << (SHORT_TAP + CNT_W);
  localparam int LOW_MOD   = 1 << KEEP_LOW;
  localparam int LIMIT     = T_L + 100;

  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        sys_rst = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        rate_short = 1'b0;
  logic        wd_dis = 1'b0;
  logic        stop_mode = 1'b0;
  logic        vec_fetch = 1'b0;
  logic        wd_rst;
  logic        wd_flag;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  watchdog_timer #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .SHORT_TAP(SHORT_TAP),
    .KEEP_LOW(KEEP_LOW), .PULSE_LEN(PULSE_LEN)
  ) u0 (
    .clk(clk), .por(por), .sys_rst(sys_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .rate_short(rate_short), .wd_dis(wd_dis), .stop_mode(stop_mode),
    .vec_fetch(vec_fetch), .wd_rst(wd_rst), .wd_flag(wd_flag)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts cycles in which wd_rst is seen high.
  task automatic idle_quiet(int n, output int highs);
    highs = 0;
    repeat (n) begin
      @(negedge clk);
      if (wd_rst) highs++;
    end
  endtask

  // Cycles from now until wd_rst is first seen high.
  task automatic measure(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!wd_rst && cyc < LIMIT);
  endtask

  // Called when wd_rst is first seen high; returns its high length.
  task automatic pulse_len(output int len);
    len = 1;
    while (wd_rst && len < 1000) begin
      @(negedge clk);
      if (wd_rst) len++;
    end
  endtask

  task automatic wait_quiet();
    while (wd_rst) @(negedge clk);
  endtask

  task automatic restart(bit short_rate);
    wait_quiet();
    rate_short = short_rate;
    sys_rst = 1'b1;
    idle(2);
    sys_rst = 1'b0;
  endtask

  task automatic service();
    bus_addr = 16'hFFFF;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = 16'h0000;
  endtask

  task automatic t_reset();
    check_eq("R1", "wd_rst after por", int'(wd_rst), 0);
    check_eq("R1", "wd_flag after por", int'(wd_flag), 0);
  endtask

  task automatic t_long_exact();
    int c;
    int len;
    restart(1'b0);
    measure(c);
    check_eq("R2", "long timeout", c, T_L);
    check_eq("R11", "flag set with pulse", int'(wd_flag), 1);
    pulse_len(len);
    check_eq("R10", "pulse length long", len, PULSE_LEN);
  endtask

  task automatic t_short_exact();
    int c;
    int len;
    restart(1'b1);
    measure(c);
    check_eq("R3", "short timeout", c, T_S);
    pulse_len(len);
    check_eq("R10", "pulse length short", len, PULSE_LEN);
    measure(c);
    check_eq("R10", "full timeout after pulse", c, T_S);
  endtask

  task automatic t_service_before();
    int c;
    restart(1'b1);
    idle(T_S - 2);
    service();
    measure(c);
    check_eq("R4", "service one edge early, short", c, T_S - ((T_S - 1) % LOW_MOD));
  endtask

  task automatic t_service_same();
    int c;
    restart(1'b1);
    idle(T_S - 1);
    service();
    measure(c);
    check_eq("R6", "service on wrap edge", c, T_S - (T_S % LOW_MOD));
  endtask

  task automatic t_service_long();
    int c;
    restart(1'b0);
    idle(T_L - 2);
    service();
    measure(c);
    check_eq("R4", "service one edge early, long", c, T_L - ((T_L - 1) % LOW_MOD));
  endtask

  task automatic t_service_mid();
    int c;
    restart(1'b1);
    idle(100);
    service();
    measure(c);
    check_eq("R4", "low stages keep phase", c, T_S - (101 % LOW_MOD));
  endtask

  task automatic t_non_service();
    int c;
    restart(1'b1);
    idle(500);
    bus_addr = 16'hFFFF;
    bus_wr = 1'b0;
    @(negedge clk);
    bus_addr = 16'hFFFE;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = 16'h0000;
    measure(c);
    check_eq("R5", "read or other address ignored", c, T_S - 502);
  endtask

  task automatic t_disable();
    int h;
    int c;
    restart(1'b1);
    wd_dis = 1'b1;
    idle_quiet(3 * T_S, h);
    check_eq("R7", "no pulse while disabled", h, 0);
    wd_dis = 1'b0;
    measure(c);
    check_eq("R7", "full timeout after enable", c, T_S);
  endtask

  task automatic t_stop();
    int h;
    int c;
    restart(1'b1);
    idle(1000);
    stop_mode = 1'b1;
    idle_quiet(3000, h);
    check_eq("R8", "no pulse in stop", h, 0);
    stop_mode = 1'b0;
    measure(c);
    check_eq("R8", "full timeout after stop", c, T_S);
  endtask

  task automatic t_vec_and_sysrst();
    int c;
    restart(1'b1);
    idle(1000);
    vec_fetch = 1'b1;
    @(negedge clk);
    vec_fetch = 1'b0;
    measure(c);
    check_eq("R9", "vector fetch full clear", c, T_S);
    restart(1'b1);
    idle(999);
    restart(1'b1);
    measure(c);
    check_eq("R9", "system reset full clear", c, T_S);
  endtask

  task automatic t_flag();
    wait_quiet();
    restart(1'b1);
    idle(3);
    check_eq("R11", "flag survives sys_rst", int'(wd_flag), 1);
    por = 1'b1;
    idle(3);
    por = 1'b0;
    idle(1);
    check_eq("R11", "flag cleared by por", int'(wd_flag), 0);
    check_eq("R1", "wd_rst low after por", int'(wd_rst), 0);
  endtask

  initial begin
    #(195000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (all requirements): actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(4);
    por = 1'b0;
    idle(1);
    t_reset();
    t_long_exact();
    t_short_exact();
    t_service_before();
    t_service_same();
    t_service_long();
    t_service_mid();
    t_non_service();
    t_disable();
    t_stop();
    t_vec_and_sysrst();
    t_flag();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule